// File: doc/BRIEF.md
# Interrupt Control and Skip Unit

This unit sits beside a 4-bit accumulator core. It decodes a small group of 10-bit instruction words. In the cycle an instruction executes, the unit does one of four things:

- switches the interrupt enable flag on or off;
- runs one of two skip tests;
- copies the accumulator into a control register;
- puts a control register's value on the read bus.

The unit holds the following state:

- the interrupt enable flag;
- an external-request flag, which an input strobe sets;
- three interrupt control registers (`ictl_a`, `ictl_b`, `ictl_pol`);
- three timer control registers (`tctl_a`, `tctl_b`, `tctl_c`);
- a 2-bit timer count-store register (`tcnt`).

The core raises `exec_valid` in the one cycle an instruction of this unit executes. In that same cycle it takes `skip_req`, which it uses to turn the next fetched word into a no-op. In that same cycle it also takes `rd_data`, which it loads into the accumulator.

Both skip tests have side effects or dependencies:

- The flag test clears the request flag after it tests it.
- The pin test takes its polarity from bit 2 of `ictl_pol`.

Every instruction in the group is one word long and takes one cycle.

Top module: `irq_skip_unit`

## Requirements
- R1: After reset, these are all 0: the enable flag, the request flag, and every control register including `tcnt`. With no instruction executing, `skip_req` and `rd_data` are also 0.
- R2: Executing 0x005 sets the enable flag at the next clock edge. Executing 0x004 clears it at the next clock edge.
- R3: A high `ext_req_set` sets the request flag at the next edge. Executing 0x038 raises `skip_req` in the same cycle if, and only if, the flag is 1. It then clears the flag at the next edge.
- R4: If `ext_req_set` is high in the same cycle as 0x038, the flag remains 1 after the edge.
- R5: Executing 0x03A raises `skip_req` in these cases:
  - bit 2 of `ictl_pol` is 1 and `int_pin` is high;
  - bit 2 of `ictl_pol` is 0 and `int_pin` is low.
- R6: The 4-bit register transfers use these opcodes (read/write):

  | Register | Read | Write |
  |---|---|---|
  | `ictl_a` | 0x054 | 0x03F |
  | `ictl_b` | 0x055 | 0x03E |
  | `ictl_pol` | 0x253 | 0x217 |
  | `tctl_a` | 0x24B | 0x20E |
  | `tctl_b` | 0x24C | 0x20F |
  | `tctl_c` | 0x24D | 0x210 |

  A write stores `acc_in` at the clock edge. A read drives the register's value on `rd_data` in the executing cycle.
- R7: Writing `tcnt` (0x212) stores only `acc_in[1:0]`. Reading it (0x24F) returns `{2'b00, tcnt}`.
- R8: An opcode outside the group produces no skip, changes no state, and drives `rd_data` to 0.
- R9: While `exec_valid` is low, the instruction word has no effect: no skip, no write, no flag change, and `rd_data` is 0.
- R10: `skip_req` is high only in a cycle where 0x038 or 0x03A executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_valid | input | 1 | An instruction executes this cycle |
| instr | input | 10 | Instruction word |
| acc_in | input | 4 | Accumulator value, used as write data |
| int_pin | input | 1 | External interrupt pin level |
| ext_req_set | input | 1 | Strobe that sets the external-request flag |
| skip_req | output | 1 | Skip the next instruction (one-cycle pulse) |
| rd_data | output | 4 | Register read value for the accumulator |
| irq_enable | output | 1 | Interrupt enable flag |
| ext_req_flag | output | 1 | External-request flag |

## Verification
- **Register file.** A wrong register value cannot be seen on the ports until that register is read. The bench therefore reads every register back on the cycle right after each write. It also reads back after writes that should be ignored: un-executed writes and foreign opcodes.
- **Polarity bit.** A wrong polarity bit appears only on the next pin test. It shows as a skip pulse that is missing, or as one that should not be there.
- **Flags.** A wrong enable flag or request flag is visible directly on its output one edge later. A wrong request flag also shows as a wrong `skip_req` on the next flag test.

// File: rtl/irqsk_pkg.sv
package irqsk_pkg;
    localparam int DATA_W  = 4;
    localparam int INSTR_W = 10;
    localparam int N_CTL   = 7;
    localparam int SEL_W   = $clog2(N_CTL);
    localparam int CNT_W   = 2;
    localparam int POL_BIT = 2;

    // Register slot indices.
    localparam int IDX_ICA = 0;
    localparam int IDX_ICB = 1;
    localparam int IDX_POL = 2;
    localparam int IDX_TCA = 3;
    localparam int IDX_TCB = 4;
    localparam int IDX_TCC = 5;
    localparam int IDX_CNT = 6;

    localparam logic [INSTR_W-1:0] OPC_IRQ_OFF = 10'h004;
    localparam logic [INSTR_W-1:0] OPC_IRQ_ON  = 10'h005;
    localparam logic [INSTR_W-1:0] OPC_TST_REQ = 10'h038;
    localparam logic [INSTR_W-1:0] OPC_TST_PIN = 10'h03A;

    typedef enum logic [2:0] {
        OP_NONE, OP_IRQ_OFF, OP_IRQ_ON, OP_TST_REQ, OP_TST_PIN, OP_RD, OP_WR
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [SEL_W-1:0] sel;
    } dec_t;

    // Read opcode of register slot i.
    function automatic logic [INSTR_W-1:0] rd_opc(input int i);
        case (i)
            IDX_ICA: return 10'h054;
            IDX_ICB: return 10'h055;
            IDX_POL: return 10'h253;
            IDX_TCA: return 10'h24B;
            IDX_TCB: return 10'h24C;
            IDX_TCC: return 10'h24D;
            default: return 10'h24F;
        endcase
    endfunction

    // Write opcode of register slot i.
    function automatic logic [INSTR_W-1:0] wr_opc(input int i);
        case (i)
            IDX_ICA: return 10'h03F;
            IDX_ICB: return 10'h03E;
            IDX_POL: return 10'h217;
            IDX_TCA: return 10'h20E;
            IDX_TCB: return 10'h20F;
            IDX_TCC: return 10'h210;
            default: return 10'h212;
        endcase
    endfunction
endpackage

// File: rtl/irqsk_decode.sv
// Instruction decoder.
// Maps an executing instruction word to an operation and a register slot.
// Assumes: at most one opcode matches any word. Words outside the group,
// and cycles without exec_valid, decode to OP_NONE.
module irqsk_decode
    import irqsk_pkg::*;
(
    input  logic               exec_valid,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Purpose: compare the word against the fixed opcodes and the per-slot opcodes.
    always_comb begin
        dec.op  = OP_NONE;
        dec.sel = '0;
        if (exec_valid) begin
            unique case (instr)
                OPC_IRQ_OFF: dec.op = OP_IRQ_OFF;
                OPC_IRQ_ON:  dec.op = OP_IRQ_ON;
                OPC_TST_REQ: dec.op = OP_TST_REQ;
                OPC_TST_PIN: dec.op = OP_TST_PIN;
                default: begin
                    for (int i = 0; i < N_CTL; i++) begin
                        if (instr == rd_opc(i)) begin
                            dec.op  = OP_RD;
                            dec.sel = SEL_W'(i);
                        end
                        if (instr == wr_opc(i)) begin
                            dec.op  = OP_WR;
                            dec.sel = SEL_W'(i);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irqsk_regs.sv
// Control register file.
// Holds N_CTL slots. The count-store slot keeps only CNT_W bits; every
// other slot keeps DATA_W bits. Reads are zero-extended to DATA_W.
// Assumes: the caller gates wr_en with a decoded write.
module irqsk_regs
    import irqsk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [N_CTL-1:0][DATA_W-1:0]  regs_q
);
    for (genvar i = 0; i < N_CTL; i++) begin : g_slot
        localparam int W = (i == IDX_CNT) ? CNT_W : DATA_W;
        logic [W-1:0] q;

        // Purpose: clear the slot on reset, or load the low W bits when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= '0;
            else if (wr_en && wr_sel == SEL_W'(i))     q <= wr_data[W-1:0];
        end

        if (W < DATA_W) begin : g_narrow
            assign regs_q[i] = {{(DATA_W-W){1'b0}}, q};
        end else begin : g_full
            assign regs_q[i] = q;
        end
    end
endmodule

// File: rtl/irqsk_flags.sv
// Flag and skip logic.
// Holds the interrupt enable flag and the external-request flag, and forms
// the combinational skip pulse.
// Assumes: at most one of the op strobes is high in any cycle.
module irqsk_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic do_off,
    input  logic do_on,
    input  logic do_tst_req,
    input  logic do_tst_pin,
    input  logic ext_set,
    input  logic pin,
    input  logic pol,
    output logic skip,
    output logic en_q,
    output logic req_q
);
    // Purpose: update the enable flag from the on and off ops.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (do_on)  en_q <= 1'b1;
        else if (do_off) en_q <= 1'b0;
    end

    // Purpose: set the request flag from the strobe, and clear it on a test;
    // the set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          req_q <= 1'b0;
        else if (ext_set)    req_q <= 1'b1;
        else if (do_tst_req) req_q <= 1'b0;
    end

    // Purpose: raise skip on a set flag, or on a pin level matching the polarity.
    always_comb begin
        skip = (do_tst_req && req_q) || (do_tst_pin && (pin == pol));
    end
endmodule

// File: rtl/irq_skip_unit.sv
// Interrupt control and skip unit (top level).
// Decodes the interrupt-control instruction group and holds the flags and
// control registers.
// Assumes: exec_valid marks the single execution cycle of instr.
module irq_skip_unit
    import irqsk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  acc_in,
    input  logic               int_pin,
    input  logic               ext_req_set,
    output logic               skip_req,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_enable,
    output logic               ext_req_flag
);
    dec_t                         dec;
    logic [N_CTL-1:0][DATA_W-1:0] regs_q;

    irqsk_decode u_dec (
        .exec_valid (exec_valid),
        .instr      (instr),
        .dec        (dec)
    );

    irqsk_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dec.op == OP_WR),
        .wr_sel  (dec.sel),
        .wr_data (acc_in),
        .regs_q  (regs_q)
    );

    irqsk_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_off     (dec.op == OP_IRQ_OFF),
        .do_on      (dec.op == OP_IRQ_ON),
        .do_tst_req (dec.op == OP_TST_REQ),
        .do_tst_pin (dec.op == OP_TST_PIN),
        .ext_set    (ext_req_set),
        .pin        (int_pin),
        .pol        (regs_q[IDX_POL][POL_BIT]),
        .skip       (skip_req),
        .en_q       (irq_enable),
        .req_q      (ext_req_flag)
    );

    // Purpose: drive the selected register on a read, and zero otherwise.
    always_comb begin
        rd_data = '0;
        if (dec.op == OP_RD) rd_data = regs_q[dec.sel];
    end
endmodule

// File: rtl/irqsk_checker.sv
// Port-level property checker, bound to irq_skip_unit.
module irqsk_checker
    import irqsk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               exec_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  acc_in,
    input logic               int_pin,
    input logic               ext_req_set,
    input logic               skip_req,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq_enable,
    input logic               ext_req_flag
);
    logic is_rd;
    always_comb begin
        is_rd = 1'b0;
        for (int i = 0; i < N_CTL; i++) if (instr == rd_opc(i)) is_rd = 1'b1;
    end

    p_skip_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> exec_valid && (instr == OPC_TST_REQ || instr == OPC_TST_PIN));
    p_irq_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == OPC_IRQ_ON |=> irq_enable);
    p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == OPC_IRQ_OFF |=> !irq_enable);
    p_req_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == OPC_TST_REQ |-> skip_req == ext_req_flag);
    p_req_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == OPC_TST_REQ && !ext_req_set |=> !ext_req_flag);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_set |=> ext_req_flag);
    p_pin_pol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == OPC_TST_PIN && $past(exec_valid && instr == wr_opc(IDX_POL))
        |-> skip_req == (int_pin == $past(acc_in[POL_BIT])));
    p_cnt_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == rd_opc(IDX_CNT) |-> rd_data[DATA_W-1:CNT_W] == '0);
    p_cnt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && instr == rd_opc(IDX_CNT) && $past(exec_valid && instr == wr_opc(IDX_CNT))
        |-> rd_data == {{(DATA_W-CNT_W){1'b0}}, $past(acc_in[CNT_W-1:0])});
    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_valid && is_rd) |-> rd_data == '0);
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> $stable(irq_enable));
endmodule

bind irq_skip_unit irqsk_checker u_chk (.*);

// File: tb/sim_irq_skip_unit.sv
module sim_irq_skip_unit;
    typedef struct packed {
        logic       ex;
        logic [9:0] ins;
        logic [3:0] acc;
        logic       pin;
        logic       stb;
        logic       sk;
        logic [3:0] rd;
        logic       en;
        logic       flg;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 44;
    // Columns: exec, instr, acc, pin, strobe | expected skip, rd, enable, flag
    // (the flags as they stand before this cycle's edge), requirement.
    localparam vec_t VEC [NV] = '{
        '{1'b1,10'h000,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b0,1'b0, 4'd8},  // R8
        '{1'b1,10'h005,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b0,1'b0, 4'd2},  // R2 on
        '{1'b0,10'h004,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd9},  // R9 not executed
        '{1'b1,10'h004,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd2},  // R2 off
        '{1'b1,10'h005,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b0,1'b0, 4'd2},  // R2
        '{1'b1,10'h03F,4'hA,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},  // R6
        '{1'b1,10'h054,4'h0,1'b0,1'b0, 1'b0,4'hA,1'b1,1'b0, 4'd6},
        '{1'b1,10'h03E,4'h5,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},
        '{1'b1,10'h055,4'h0,1'b0,1'b0, 1'b0,4'h5,1'b1,1'b0, 4'd6},
        '{1'b1,10'h217,4'h4,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},
        '{1'b1,10'h253,4'h0,1'b0,1'b0, 1'b0,4'h4,1'b1,1'b0, 4'd6},
        '{1'b1,10'h03A,4'h0,1'b1,1'b0, 1'b1,4'h0,1'b1,1'b0, 4'd5},  // R5 pol 1, high
        '{1'b1,10'h03A,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd5},
        '{1'b1,10'h217,4'h3,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd5},
        '{1'b1,10'h03A,4'h0,1'b0,1'b0, 1'b1,4'h0,1'b1,1'b0, 4'd5},  // R5 pol 0, low
        '{1'b1,10'h03A,4'h0,1'b1,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd5},
        '{1'b1,10'h20E,4'hC,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},
        '{1'b1,10'h24B,4'h0,1'b0,1'b0, 1'b0,4'hC,1'b1,1'b0, 4'd6},
        '{1'b1,10'h20F,4'h9,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},
        '{1'b1,10'h24C,4'h0,1'b0,1'b0, 1'b0,4'h9,1'b1,1'b0, 4'd6},
        '{1'b1,10'h210,4'h6,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd6},
        '{1'b1,10'h24D,4'h0,1'b0,1'b0, 1'b0,4'h6,1'b1,1'b0, 4'd6},
        '{1'b1,10'h212,4'hF,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd7},  // R7
        '{1'b1,10'h24F,4'h0,1'b0,1'b0, 1'b0,4'h3,1'b1,1'b0, 4'd7},
        '{1'b1,10'h212,4'h6,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd7},
        '{1'b1,10'h24F,4'hF,1'b0,1'b0, 1'b0,4'h2,1'b1,1'b0, 4'd7},
        '{1'b1,10'h038,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd3},  // R3 flag clear
        '{1'b1,10'h000,4'h0,1'b0,1'b1, 1'b0,4'h0,1'b1,1'b0, 4'd3},
        '{1'b1,10'h000,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b1, 4'd3},
        '{1'b1,10'h038,4'h0,1'b0,1'b0, 1'b1,4'h0,1'b1,1'b1, 4'd3},  // R3 skip
        '{1'b1,10'h000,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd3},
        '{1'b1,10'h000,4'h0,1'b0,1'b1, 1'b0,4'h0,1'b1,1'b0, 4'd4},
        '{1'b1,10'h038,4'h0,1'b0,1'b1, 1'b1,4'h0,1'b1,1'b1, 4'd4},  // R4 collision
        '{1'b1,10'h000,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b1, 4'd4},
        '{1'b1,10'h038,4'h0,1'b0,1'b0, 1'b1,4'h0,1'b1,1'b1, 4'd3},
        '{1'b1,10'h3FF,4'hF,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd8},  // R8
        '{1'b0,10'h054,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd9},  // R9 read gated
        '{1'b0,10'h03F,4'h1,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd9},
        '{1'b1,10'h054,4'h0,1'b0,1'b0, 1'b0,4'hA,1'b1,1'b0, 4'd9},
        '{1'b1,10'h23F,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd8},
        '{1'b1,10'h054,4'h0,1'b0,1'b0, 1'b0,4'hA,1'b1,1'b0, 4'd8},
        '{1'b1,10'h24B,4'h0,1'b0,1'b0, 1'b0,4'hC,1'b1,1'b0, 4'd8},
        '{1'b0,10'h03A,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd10}, // R10
        '{1'b1,10'h004,4'h0,1'b0,1'b0, 1'b0,4'h0,1'b1,1'b0, 4'd2}
    };

    localparam logic [9:0] RD_OPS [7] = '{10'h054,10'h055,10'h253,10'h24B,10'h24C,10'h24D,10'h24F};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_valid = 1'b0;
    logic [9:0] instr = '0;
    logic [3:0] acc_in = '0;
    logic       int_pin = 1'b0;
    logic       ext_req_set = 1'b0;
    logic       skip_req;
    logic [3:0] rd_data;
    logic       irq_enable;
    logic       ext_req_flag;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    irq_skip_unit u0 (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
        .acc_in(acc_in), .int_pin(int_pin), .ext_req_set(ext_req_set),
        .skip_req(skip_req), .rd_data(rd_data), .irq_enable(irq_enable),
        .ext_req_flag(ext_req_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ex, input logic [9:0] ins, input logic [3:0] acc,
                         input logic pin, input logic stb);
        @(negedge clk);
        exec_valid = ex; instr = ins; acc_in = acc; int_pin = pin; ext_req_set = stb;
        #4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        check("R1", "enable in reset", int'(irq_enable), 0);
        check("R1", "flag in reset", int'(ext_req_flag), 0);
        check("R1", "skip in reset", int'(skip_req), 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            string tag;
            tag = $sformatf("R%0d row%0d", VEC[i].req, i);
            drive(VEC[i].ex, VEC[i].ins, VEC[i].acc, VEC[i].pin, VEC[i].stb);
            check(tag, "skip", int'(skip_req), int'(VEC[i].sk));
            check(tag, "rd", int'(rd_data), int'(VEC[i].rd));
            check(tag, "enable", int'(irq_enable), int'(VEC[i].en));
            check(tag, "flag", int'(ext_req_flag), int'(VEC[i].flg));
        end

        // R1: load state, reset mid-run, then confirm everything clears.
        drive(1'b1, 10'h005, 4'h0, 1'b0, 1'b1);
        drive(1'b1, 10'h212, 4'h3, 1'b0, 1'b0);
        drive(1'b0, 10'h000, 4'h0, 1'b0, 1'b0);
        check("R1", "flag before reset", int'(ext_req_flag), 1);
        check("R1", "enable before reset", int'(irq_enable), 1);
        rst_n = 1'b0;
        drive(1'b0, 10'h000, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        check("R1", "enable after reset", int'(irq_enable), 0);
        check("R1", "flag after reset", int'(ext_req_flag), 0);
        for (int k = 0; k < 7; k++) begin
            drive(1'b1, RD_OPS[k], 4'hF, 1'b0, 1'b0);
            check("R1", $sformatf("reg read %0h after reset", RD_OPS[k]), int'(rd_data), 0);
        end
        // R3: a flag test with the flag clear does not skip.
        drive(1'b1, 10'h038, 4'h0, 1'b0, 1'b0);
        check("R3", "no skip with flag clear", int'(skip_req), 0);
        // R5: after reset the polarity bit is 0, so a low pin skips.
        drive(1'b1, 10'h03A, 4'h0, 1'b0, 1'b0);
        check("R5", "low pin after reset", int'(skip_req), 1);
        drive(1'b0, 10'h000, 4'h0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule